// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block takes a 32-bit word, picks one of its two 16-bit halves, reads it as an IEEE binary16 number and produces the binary32 value that represents it exactly. No rounding is ever needed, because every binary16 value has an exact binary32 form. The datapath itself is combinational. One register stage at the output gives a one-cycle latency, and a valid bit travels with the data.

Two mode inputs change the result. The alternative-format input makes the all-ones half exponent an ordinary normal exponent, so that encoding stops meaning infinity or NaN. The default-NaN input replaces every NaN result with the canonical quiet NaN. A signalling NaN input is quieted and raises a one-cycle invalid flag next to the result. The block does not keep flags between operations. Subnormal halves are normalised in one pass by a priority encoder and a barrel shifter.

Top module: `half_to_single_widen`

## Requirements
- R1: With `take_upper` high the converted half is `src_word[31:16]`; otherwise it is `src_word[15:0]`. Inside the half, bit 15 is the sign, bits 14:10 the exponent and bits 9:0 the fraction.
- R2: A half whose exponent and fraction are both zero gives a binary32 zero that keeps the sign (0x00000000 or 0x80000000).
- R3: A subnormal half (exponent 0, fraction nonzero) gives a normal binary32 value. If the fraction must shift left by n to put its leading one at bit 10, the result exponent is 113-n and the result fraction is the 10 bits below that leading one, followed by 13 zero bits.
- R4: A normal half (exponent 1..30) gives exponent half_exponent+112 and fraction half_fraction followed by 13 zero bits. The sign is unchanged.
- R5: With `alt_half` low, exponent 31 with fraction 0 gives a signed infinity: exponent 0xFF, fraction 0.
- R6: With `alt_half` low and `default_nan` low, a quiet NaN half (exponent 31, fraction bit 9 set) gives exponent 0xFF and fraction = half_fraction followed by 13 zero bits. Sign and payload are kept and `invalid_o` stays low.
- R7: With `alt_half` low, a signalling NaN half (exponent 31, fraction nonzero, fraction bit 9 clear) raises `invalid_o` and gets result bit 22 forced to 1. When `default_nan` is low, the payload and sign are kept as in R6.
- R8: With `alt_half` low and `default_nan` high, every NaN half gives exactly 0x7FC00000. A signalling input still raises `invalid_o`.
- R9: With `alt_half` high, exponent 31 follows the R4 path (result exponent 143), and `invalid_o` never rises.
- R10: Results appear one clock after the input is accepted. `out_valid` is `in_valid` delayed by one cycle, and `invalid_o` is high only when `out_valid` is high.
- R11: While `rst_n` is low at a rising clock edge, `out_valid`, `out_word` and `invalid_o` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is presented this cycle |
| src_word | input | 32 | Word holding two binary16 values |
| take_upper | input | 1 | 1 selects bits 31:16, 0 selects bits 15:0 |
| alt_half | input | 1 | Alternative format: exponent 31 is a normal exponent |
| default_nan | input | 1 | Force every NaN result to 0x7FC00000 |
| out_valid | output | 1 | Result valid this cycle |
| out_word | output | 32 | binary32 result |
| invalid_o | output | 1 | Pulse: a signalling NaN was converted |

## Verification
The hardest situation to reach is a subnormal half whose leading one sits at each of the ten possible fraction positions while the other half of the word holds unrelated data. A shift-amount error in a single barrel stage changes only a few of those positions. The stimulus therefore sweeps all 65536 half encodings, alternates which half of the word carries them, fills the other half with random bits and rotates the mode inputs. Directed cases before the sweep cover the edges: the smallest and largest subnormals, a NaN in each mode, and exponent 31 in alternative format.

// File: rtl/h2s_pkg.sv
// Shared formats and constants for the half-to-single widening converter.
// Assumes IEEE binary16 input and binary32 output layouts.
package h2s_pkg;
    localparam int HALF_EXP_W  = 5;
    localparam int HALF_FRAC_W = 10;
    localparam int HALF_W      = 1 + HALF_EXP_W + HALF_FRAC_W;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;
    localparam int SGL_W       = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int WORD_W      = 2 * HALF_W;
    localparam int HALF_BIAS   = (1 << (HALF_EXP_W - 1)) - 1;
    localparam int SGL_BIAS    = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int BIAS_GAP    = SGL_BIAS - HALF_BIAS;
    localparam int SUB_BASE    = BIAS_GAP + 1;
    localparam int ALIGN_SH    = SGL_FRAC_W - HALF_FRAC_W;

    typedef struct packed {
        logic                   sign;
        logic [HALF_EXP_W-1:0]  expo;
        logic [HALF_FRAC_W-1:0] frac;
    } half_t;

    typedef struct packed {
        logic                  sign;
        logic [SGL_EXP_W-1:0]  expo;
        logic [SGL_FRAC_W-1:0] frac;
    } single_t;

    typedef enum logic [2:0] {
        HC_ZERO,
        HC_SUB,
        HC_NORM,
        HC_INF,
        HC_NAN
    } hclass_e;
endpackage

// File: rtl/half_pick.sv
// Selects one binary16 field from a word and classifies it.
// Assumes the upper field lives in the high half of the word.
module half_pick
    import h2s_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              upper_i,
    input  logic              alt_i,
    output half_t             fld_o,
    output hclass_e           cls_o
);
    // Field selection by the top/bottom control.
    assign fld_o = upper_i ? word_i[WORD_W-1:HALF_W] : word_i[HALF_W-1:0];

    // Class decode; the all-ones exponent is special only outside alternative format.
    always_comb begin
        if (fld_o.expo == '0) begin
            cls_o = (fld_o.frac == '0) ? HC_ZERO : HC_SUB;
        end else if ((fld_o.expo == '1) && !alt_i) begin
            cls_o = (fld_o.frac == '0) ? HC_INF : HC_NAN;
        end else begin
            cls_o = HC_NORM;
        end
    end
endmodule

// File: rtl/lead_one_norm.sv
// Normalises a nonzero fraction so its leading one lands just above the
// field: a priority encoder finds the top one, a log-depth barrel shifter moves it.
// Assumes a nonzero input; for zero the outputs are meaningless.
module lead_one_norm #(
    parameter  int W   = 10,
    localparam int SHW = $clog2(W + 1)
) (
    input  logic [W-1:0]   mant_i,
    output logic [SHW-1:0] shift_o,
    output logic [W-1:0]   frac_o,
    output logic           lead_o
);
    logic [SHW-1:0] top_pos;
    logic [W:0]     stage [0:SHW];

    // Priority encoder: position of the highest set bit.
    always_comb begin
        top_pos = '0;
        for (int i = 0; i < W; i++) begin
            if (mant_i[i]) top_pos = SHW'(i);
        end
    end

    // Distance from that bit to the implicit-one position W.
    assign shift_o  = SHW'(W) - top_pos;
    assign stage[0] = {1'b0, mant_i};

    // One conditional power-of-two shift per bit of the shift amount.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        assign stage[k+1] = shift_o[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign frac_o = stage[SHW][W-1:0];
    assign lead_o = stage[SHW][W];
endmodule

// File: rtl/nan_shaper.sv
// Produces the binary32 NaN fraction and sign from an aligned payload:
// quiets signalling NaNs, flags them, and applies the default-NaN override.
module nan_shaper
    import h2s_pkg::*;
(
    input  logic                  sign_i,
    input  logic [SGL_FRAC_W-1:0] frac_i,
    input  logic                  dflt_i,
    output logic                  sign_o,
    output logic [SGL_FRAC_W-1:0] frac_o,
    output logic                  signal_o
);
    localparam logic [SGL_FRAC_W-1:0] QUIET = SGL_FRAC_W'(1) << (SGL_FRAC_W - 1);

    // A clear quiet bit marks a signalling NaN.
    assign signal_o = !frac_i[SGL_FRAC_W-1];

    // Default NaN drops payload and sign; otherwise only the quiet bit is forced.
    always_comb begin
        if (dflt_i) begin
            frac_o = QUIET;
            sign_o = 1'b0;
        end else begin
            frac_o = frac_i | QUIET;
            sign_o = sign_i;
        end
    end
endmodule

// File: rtl/half_to_single_widen.sv
// Exact binary16 to binary32 widening with one output register stage.
// Assumes synchronous active-low reset; inputs are used only with in_valid high.
module half_to_single_widen
    import h2s_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] src_word,
    input  logic              take_upper,
    input  logic              alt_half,
    input  logic              default_nan,
    output logic              out_valid,
    output logic [SGL_W-1:0]  out_word,
    output logic              invalid_o
);
    localparam int SHW = $clog2(HALF_FRAC_W + 1);

    half_t                  fld;
    hclass_e                cls;
    logic [SHW-1:0]         sub_shift;
    logic [HALF_FRAC_W-1:0] sub_frac;
    logic                   norm_lead;
    logic                   is_sub;
    logic                   nan_sign;
    logic [SGL_FRAC_W-1:0]  nan_frac;
    logic                   nan_sig;
    single_t                res_c;
    logic                   inv_c;
    single_t                res_q;
    logic                   inv_q;
    logic                   vld_q;

    half_pick u_pick (
        .word_i  (src_word),
        .upper_i (take_upper),
        .alt_i   (alt_half),
        .fld_o   (fld),
        .cls_o   (cls)
    );

    lead_one_norm #(.W(HALF_FRAC_W)) u_norm (
        .mant_i  (fld.frac),
        .shift_o (sub_shift),
        .frac_o  (sub_frac),
        .lead_o  (norm_lead)
    );

    nan_shaper u_nan (
        .sign_i   (fld.sign),
        .frac_i   ({fld.frac, {ALIGN_SH{1'b0}}}),
        .dflt_i   (default_nan),
        .sign_o   (nan_sign),
        .frac_o   (nan_frac),
        .signal_o (nan_sig)
    );

    assign is_sub = (cls == HC_SUB);

    // Assembles the binary32 result for each input class.
    always_comb begin
        res_c.sign = fld.sign;
        res_c.expo = '0;
        res_c.frac = '0;
        inv_c      = 1'b0;
        case (cls)
            HC_ZERO: begin
                res_c.expo = '0;
                res_c.frac = '0;
            end
            HC_SUB: begin
                res_c.expo = SGL_EXP_W'(SUB_BASE) - SGL_EXP_W'(sub_shift);
                res_c.frac = {sub_frac, {ALIGN_SH{1'b0}}};
            end
            HC_INF: begin
                res_c.expo = '1;
                res_c.frac = '0;
            end
            HC_NAN: begin
                res_c.sign = nan_sign;
                res_c.expo = '1;
                res_c.frac = nan_frac;
                inv_c      = nan_sig;
            end
            default: begin
                res_c.expo = SGL_EXP_W'(fld.expo) + SGL_EXP_W'(BIAS_GAP);
                res_c.frac = {fld.frac, {ALIGN_SH{1'b0}}};
            end
        endcase
    end

    // Output stage: captures the result and the flag together with the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
            inv_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            res_q <= res_c;
            inv_q <= inv_c && in_valid;
        end
    end

    assign out_valid = vld_q;
    assign out_word  = res_q;
    assign invalid_o = inv_q;
endmodule

// File: rtl/half_to_single_widen_chk.sv
// Property checker for the widening converter; attached by bind below.
module half_to_single_widen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] src_word,
    input logic        take_upper,
    input logic        alt_half,
    input logic        default_nan,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        invalid_o,
    input logic        is_sub,
    input logic        norm_lead
);
    logic [15:0] hv;
    assign hv = take_upper ? src_word[31:16] : src_word[15:0];

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> out_valid);
    a_r7_flag_means_quiet_nan: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (out_word[30:22] == 9'h1FF));
    a_r9_alt_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && alt_half) |=> !invalid_o);
    a_r8_default_nan_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && default_nan && !alt_half && hv[14:10] == 5'h1F && hv[9:0] != 10'd0)
        |=> (out_word == 32'h7FC0_0000));
    a_r2_signed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hv[14:0] == 15'd0) |=> (out_word == {$past(hv[15]), 31'd0}));
    a_r3_shift_finds_lead: assert property (@(posedge clk) disable iff (!rst_n)
        is_sub |-> norm_lead);
endmodule

bind half_to_single_widen half_to_single_widen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_word    (src_word),
    .take_upper  (take_upper),
    .alt_half    (alt_half),
    .default_nan (default_nan),
    .out_valid   (out_valid),
    .out_word    (out_word),
    .invalid_o   (invalid_o),
    .is_sub      (is_sub),
    .norm_lead   (norm_lead)
);

// File: tb/half_to_single_widen_test.sv
module half_to_single_widen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_word = '0;
    logic        take_upper = 1'b0;
    logic        alt_half = 1'b0;
    logic        default_nan = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        invalid_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        bit          vld;
        logic [31:0] word;
        bit          inv;
        string       tag;
    } exp_t;
    exp_t pending[$];

    always #5 clk = ~clk;

    half_to_single_widen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
        .take_upper(take_upper), .alt_half(alt_half), .default_nan(default_nan),
        .out_valid(out_valid), .out_word(out_word), .invalid_o(invalid_o)
    );

    // Behavioural reference written from the requirements.
    function automatic void model(input logic [31:0] w, input bit up, input bit alt,
                                  input bit dn, output logic [31:0] r, output bit inv,
                                  output string tag);
        logic [15:0] h;
        bit s;
        int e, m, ex, f;
        h = up ? w[31:16] : w[15:0];
        s = h[15]; e = int'(h[14:10]); m = int'(h[9:0]);
        inv = 0;
        if (e == 0 && m == 0) begin
            r = {s, 31'd0}; tag = "R2";
        end else if (e == 0) begin
            ex = 113; f = m;
            while (f < 1024) begin f = f * 2; ex = ex - 1; end
            r = {s, 8'(ex), 10'(f), 13'd0}; tag = "R3";
        end else if (e == 31 && !alt) begin
            if (m == 0) begin
                r = {s, 8'hFF, 23'd0}; tag = "R5";
            end else begin
                f = m * 8192;
                inv = (f < 32'h40_0000) || (f >= 32'h80_0000);
                inv = (f / 32'h40_0000) % 2 == 0;
                f = f | 32'h40_0000;
                if (dn) begin r = 32'h7FC0_0000; tag = "R8"; end
                else begin r = {s, 8'hFF, 23'(f)}; tag = inv ? "R7" : "R6"; end
            end
        end else begin
            r = {s, 8'(e + 112), 10'(m), 13'd0}; tag = alt && e == 31 ? "R9" : "R4";
        end
        if (up) tag = {tag, "/R1"};
    endfunction

    task automatic compare_now();
        exp_t x;
        x = pending.pop_front();
        compared++;
        if (out_valid !== x.vld) begin
            mismatched++;
            $display("FAIL R10 out_valid actual=%0b expected=%0b", out_valid, x.vld);
        end else if (x.vld) begin
            if (out_word !== x.word || invalid_o !== x.inv) begin
                mismatched++;
                $display("FAIL %s word/flag actual=%08h/%0b expected=%08h/%0b",
                         x.tag, out_word, invalid_o, x.word, x.inv);
            end
        end else if (invalid_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R10 invalid_o without valid actual=%0b expected=0", invalid_o);
        end
    endtask

    // Check the previous cycle, then drive and predict the next one.
    task automatic step(input bit v, input logic [31:0] w, input bit up,
                        input bit alt, input bit dn);
        exp_t x;
        @(negedge clk);
        compare_now();
        in_valid = v; src_word = w; take_upper = up; alt_half = alt; default_nan = dn;
        x.vld = v;
        model(w, up, alt, dn, x.word, x.inv, x.tag);
        pending.push_back(x);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            compared++; mismatched++;
            $display("FAIL R10 watchdog actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        exp_t x;
        src_word = 32'hFFFF_FFFF; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset clears all outputs.
        compared++;
        if (out_valid !== 1'b0 || out_word !== 32'd0 || invalid_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R11 reset actual=%0b/%08h/%0b expected=0/00000000/0",
                     out_valid, out_word, invalid_o);
        end
        rst_n = 1'b1; in_valid = 1'b0;
        x.vld = 0; x.word = '0; x.inv = 0; x.tag = "R10";
        pending.push_back(x);

        // Directed corners.
        step(1, 32'h0000_0000, 0, 0, 0);   // R2 +0
        step(1, 32'h8000_1234, 1, 0, 0);   // R2 -0, R1 upper
        step(1, 32'h0000_0001, 0, 0, 0);   // R3 smallest subnormal
        step(1, 32'h0000_0200, 0, 0, 0);   // R3
        step(1, 32'h03FF_0000, 1, 0, 0);   // R3 largest subnormal, upper
        step(1, 32'h0000_3C00, 0, 0, 0);   // R4 1.0
        step(1, 32'hAAAA_7BFF, 0, 0, 0);   // R4 max normal
        step(0, 32'h0000_7C01, 0, 0, 0);   // R10 idle
        step(1, 32'h7C00_0000, 1, 0, 0);   // R5 +inf
        step(1, 32'h0000_FC00, 0, 0, 1);   // R5 -inf, default NaN irrelevant
        step(1, 32'h0000_7E01, 0, 0, 0);   // R6 quiet NaN
        step(1, 32'h0000_FC01, 0, 0, 0);   // R7 signalling NaN
        step(1, 32'hFD55_0000, 1, 0, 1);   // R8 signalling with default NaN
        step(1, 32'h0000_FE00, 0, 0, 1);   // R8 quiet with default NaN
        step(1, 32'h0000_7C00, 0, 1, 0);   // R9 alt exponent 31
        step(1, 32'hFFFF_0000, 1, 1, 1);   // R9 alt all ones
        step(1, 32'h0000_7C01, 0, 1, 0);   // R9 no flag

        // Sweep every half encoding, alternating field and modes.
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] junk;
            bit up;
            junk = 16'($urandom);
            up = (i % 3) == 1;
            if (i % 11 == 5) step(0, $urandom, up, 0, 0);
            step(1, up ? {16'(i), junk} : {junk, 16'(i)}, up, ((i / 7) % 2) == 1,
                 ((i / 5) % 2) == 1);
        end
        step(0, 32'd0, 0, 0, 0);
        @(negedge clk);
        compare_now();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule